// File: doc/BRIEF.md
# DRAM Address Multiplexer with Byte-Lane Parity

This block sits between a 16-bit processor bus and an asynchronous DRAM array. It folds the processor address onto one narrow DRAM address bus, presenting a row slice or a column slice depending on a registered phase control. The lower eight DRAM lines always carry the same two address windows. The upper lines carry interleaved odd/even address pairs, so every bank size from the smallest to the largest uses one fixed wiring and nothing has to be configured. Strobe timing and refresh are left to the surrounding controller, which simply toggles the phase input.

The block also protects the data path with one odd-parity bit per byte lane. On a write it produces the parity bits to be stored beside the data. On a read it compares the returned bits with the data and raises a one-cycle bus-error pulse when an enabled lane disagrees. Parity is inactive when the parity enable is low or when an external bus master owns the cycle.

Top module: `dram_amux_parity`

## Requirements
- R1: While the registered phase is row, `dram_addr[7:0]` equals `cpu_addr[16:9]`, and `dram_addr[8]`, `dram_addr[9]`, `dram_addr[10]` equal `cpu_addr[18]`, `cpu_addr[20]`, `cpu_addr[22]`.
- R2: While the registered phase is column, `dram_addr[7:0]` equals `cpu_addr[8:1]`, and `dram_addr[8]`, `dram_addr[9]`, `dram_addr[10]` equal `cpu_addr[17]`, `cpu_addr[19]`, `cpu_addr[21]`.
- R3: `col_sel` is sampled on the rising clock edge (0 selects row, 1 selects column). A change has no effect on `dram_addr` until the next rising edge and takes effect right after it.
- R4: During a write (`wr_stb`=1, `par_en`=1, `ext_master`=0), `par_out[0]` is the odd-parity bit of `wr_data[15:8]` when `byte_en[0]`=1, and `par_out[1]` is the odd-parity bit of `wr_data[7:0]` when `byte_en[1]`=1. Odd parity means the byte and its bit together hold an odd number of ones. A lane that is not enabled, and both lanes outside a write, output 0.
- R5: On a rising edge where `rd_stb`=1 with parity active, if an enabled lane's data byte and its `rd_par` bit hold an even number of ones, `bus_err` is 1 for the following cycle only (unless the next cycle is also a failing read).
- R6: A lane whose `byte_en` bit is 0 never causes `bus_err`, whatever its data and parity bit are.
- R7: With `par_en`=0, `par_out` is 0 and `bus_err` stays 0.
- R8: With `ext_master`=1, `par_out` is 0 and `bus_err` stays 0.
- R9: Synchronous reset (`rst`=1) sets the phase to row and `bus_err` to 0.
- R10: `bus_err` is 0 after any edge where `rd_stb`=0, even if the read data and parity disagree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 24 | Processor byte address |
| col_sel | input | 1 | Phase control: 0 row, 1 column, registered |
| dram_addr | output | 11 | Multiplexed DRAM address |
| wr_stb | input | 1 | Write cycle in progress |
| rd_stb | input | 1 | Read data is sampled on this edge |
| byte_en | input | 2 | Lane enables: bit 0 for D15..D8, bit 1 for D7..D0 |
| par_en | input | 1 | Parity generation and checking enable |
| ext_master | input | 1 | An external master owns the access |
| wr_data | input | 16 | Write data |
| par_out | output | 2 | Parity bits to store: bit 0 for D15..D8, bit 1 for D7..D0 |
| rd_data | input | 16 | Read data from the array |
| rd_par | input | 2 | Stored parity bits read back, same lane order as `par_out` |
| bus_err | output | 1 | Registered parity error pulse |

## Verification
A stuck or mis-reset phase register shows at once on `dram_addr`: after the first edge that follows a change of `col_sel`, the outputs hold the wrong address window, and a one-cycle lag or lead is visible by sampling on both sides of that edge. A fault in the error register or its gating shows one cycle after the sampling edge as a missing pulse, a pulse with a disabled lane, parity off or an external master, or a pulse that is still high a cycle later. Lane-order mistakes show up combinationally on `par_out` and, on reads, as a reported lane that does not match the corrupted one.

// File: rtl/dramx_pkg.sv
package dramx_pkg;

    localparam int BYTE_W     = 8;
    localparam int LANES      = 2;
    localparam int DATA_W     = BYTE_W * LANES;

    localparam int BASE_LINES = 8;   // lines that carry a contiguous window
    localparam int ROW_LSB    = 9;   // first row address bit on line 0
    localparam int COL_LSB    = 1;   // first column address bit on line 0
    localparam int PAIR_ROW0  = 18;  // row bit on the first upper line
    localparam int PAIR_COL0  = 17;  // column bit on the first upper line
    localparam int PAIR_STEP  = 2;   // distance between successive pairs

    typedef enum logic {
        PH_ROW = 1'b0,
        PH_COL = 1'b1
    } phase_e;

    typedef struct packed {
        logic             active;   // parity is in force for this access
        logic [LANES-1:0] lanes;    // lanes taking part
    } par_ctl_t;

    // Bit that makes the byte plus itself hold an odd count of ones.
    function automatic logic odd_fill(input logic [BYTE_W-1:0] b);
        return ~(^b);
    endfunction

    // True when byte plus stored bit hold an even count of ones.
    function automatic logic lane_broken(input logic [BYTE_W-1:0] b,
                                         input logic              p);
        return ~(^{b, p});
    endfunction

endpackage

// File: rtl/dramx_addr_mux.sv
module dramx_addr_mux
    import dramx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PAIRS  = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          col_sel,
    input  logic [ADDR_W-1:0]             cpu_addr,
    output logic [BASE_LINES+PAIRS-1:0]   dram_addr
);
    localparam int OUT_W = BASE_LINES + PAIRS;

    phase_e           phase_q;
    logic [OUT_W-1:0] row_bits;
    logic [OUT_W-1:0] col_bits;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_ROW;
        else     phase_q <= col_sel ? PH_COL : PH_ROW;
    end

    genvar gi;
    generate
        for (gi = 0; gi < BASE_LINES; gi++) begin : g_base
            assign row_bits[gi] = cpu_addr[ROW_LSB + gi];
            assign col_bits[gi] = cpu_addr[COL_LSB + gi];
        end
        for (gi = 0; gi < PAIRS; gi++) begin : g_pair
            assign row_bits[BASE_LINES + gi] = cpu_addr[PAIR_ROW0 + PAIR_STEP*gi];
            assign col_bits[BASE_LINES + gi] = cpu_addr[PAIR_COL0 + PAIR_STEP*gi];
        end
    endgenerate

    always_comb begin
        unique case (phase_q)
            PH_COL:  dram_addr = col_bits;
            default: dram_addr = row_bits;
        endcase
    end

endmodule

// File: rtl/dramx_par_gen.sv
module dramx_par_gen
    import dramx_pkg::*;
(
    input  logic              wr_stb,
    input  par_ctl_t          ctl,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  par_out
);
    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            logic [BYTE_W-1:0] lane_byte;
            assign lane_byte   = wr_data[DATA_W-1-gl*BYTE_W -: BYTE_W];
            assign par_out[gl] = wr_stb && ctl.active && ctl.lanes[gl]
                                 ? odd_fill(lane_byte) : 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dramx_par_chk.sv
module dramx_par_chk
    import dramx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  par_ctl_t          ctl,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par,
    output logic              bus_err
);
    logic [LANES-1:0] lane_bad;
    logic             err_d;

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            logic [BYTE_W-1:0] lane_byte;
            assign lane_byte    = rd_data[DATA_W-1-gl*BYTE_W -: BYTE_W];
            assign lane_bad[gl] = lane_broken(lane_byte, rd_par[gl]);
        end
    endgenerate

    assign err_d = rd_stb && ctl.active && |(lane_bad & ctl.lanes);

    always_ff @(posedge clk) begin
        if (rst) bus_err <= 1'b0;
        else     bus_err <= err_d;
    end

    AST_ERR_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(rd_stb)); // R10

    AST_ERR_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(ctl.active)); // R7

endmodule

// File: rtl/dram_amux_parity.sv
module dram_amux_parity
    import dramx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PAIRS  = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic                        col_sel,
    output logic [BASE_LINES+PAIRS-1:0] dram_addr,
    input  logic                        wr_stb,
    input  logic                        rd_stb,
    input  logic [LANES-1:0]            byte_en,
    input  logic                        par_en,
    input  logic                        ext_master,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [LANES-1:0]            par_out,
    input  logic [DATA_W-1:0]           rd_data,
    input  logic [LANES-1:0]            rd_par,
    output logic                        bus_err
);
    par_ctl_t ctl;

    assign ctl.active = par_en && !ext_master;
    assign ctl.lanes  = byte_en;

    dramx_addr_mux #(
        .ADDR_W (ADDR_W),
        .PAIRS  (PAIRS)
    ) u_amux (
        .clk       (clk),
        .rst       (rst),
        .col_sel   (col_sel),
        .cpu_addr  (cpu_addr),
        .dram_addr (dram_addr)
    );

    dramx_par_gen u_pgen (
        .wr_stb  (wr_stb),
        .ctl     (ctl),
        .wr_data (wr_data),
        .par_out (par_out)
    );

    dramx_par_chk u_pchk (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (rd_stb),
        .ctl     (ctl),
        .rd_data (rd_data),
        .rd_par  (rd_par),
        .bus_err (bus_err)
    );

    AST_ROW_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(col_sel)) |-> (dram_addr[7:0] == cpu_addr[16:9])); // R1

    AST_COL_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(col_sel)) |-> (dram_addr[7:0] == cpu_addr[8:1])); // R2

    AST_WR_UPPER_ODD: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && par_en && !ext_master && byte_en[0])
            |-> (^{wr_data[15:8], par_out[0]})); // R4

    AST_WR_LOWER_ODD: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && par_en && !ext_master && byte_en[1])
            |-> (^{wr_data[7:0], par_out[1]})); // R4

    AST_WR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!par_en || ext_master) |-> (par_out == '0)); // R8

endmodule

// File: tb/dram_amux_parity_test.sv
`timescale 1ns/1ps
module dram_amux_parity_test;

    localparam real HALF = 4.0;   // 125 MHz

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] cpu_addr;
    logic        col_sel;
    logic [10:0] dram_addr;
    logic        wr_stb, rd_stb;
    logic [1:0]  byte_en;
    logic        par_en, ext_master;
    logic [15:0] wr_data, rd_data;
    logic [1:0]  par_out, rd_par;
    logic        bus_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(HALF) clk = ~clk;

    dram_amux_parity uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .col_sel(col_sel),
        .dram_addr(dram_addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .byte_en(byte_en), .par_en(par_en), .ext_master(ext_master),
        .wr_data(wr_data), .par_out(par_out), .rd_data(rd_data),
        .rd_par(rd_par), .bus_err(bus_err)
    );

    // Expected windows straight from R1/R2
    function automatic logic [10:0] want_row(input logic [23:0] a);
        logic [10:0] r;
        for (int i = 0; i < 8; i++) r[i] = a[9+i];
        r[8] = a[18]; r[9] = a[20]; r[10] = a[22];
        return r;
    endfunction

    function automatic logic [10:0] want_col(input logic [23:0] a);
        logic [10:0] r;
        for (int i = 0; i < 8; i++) r[i] = a[1+i];
        r[8] = a[17]; r[9] = a[19]; r[10] = a[21];
        return r;
    endfunction

    // Odd-parity bit by counting ones
    function automatic logic odd_bit(input logic [7:0] b);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += b[i];
        return (ones % 2 == 0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    localparam logic [23:0] ADDR_TBL [0:7] = '{
        24'h000000, 24'hFFFFFF, 24'hAAAAAA, 24'h555555,
        24'h123456, 24'h800201, 24'h0F0F0F, 24'h7FFE01
    };

    // {data[15:0], byte_en[1:0], par_en, ext_master, corrupt[1:0]}
    localparam logic [21:0] PAR_TBL [0:9] = '{
        {16'h0000, 2'b11, 1'b1, 1'b0, 2'b00},
        {16'hFFFF, 2'b11, 1'b1, 1'b0, 2'b01},
        {16'hA5C3, 2'b11, 1'b1, 1'b0, 2'b10},
        {16'h8001, 2'b11, 1'b1, 1'b0, 2'b11},
        {16'h1234, 2'b01, 1'b1, 1'b0, 2'b10},
        {16'h7E81, 2'b10, 1'b1, 1'b0, 2'b01},
        {16'hDEAD, 2'b11, 1'b0, 1'b0, 2'b11},
        {16'hBEEF, 2'b11, 1'b1, 1'b1, 2'b11},
        {16'h0100, 2'b10, 1'b1, 1'b0, 2'b10},
        {16'hFE7F, 2'b01, 1'b1, 1'b0, 2'b01}
    };

    initial begin
        #(2.0 * HALF * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired, all requirements unfinished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cpu_addr = 24'hAAAAAA; col_sel = 1'b1;
        wr_stb = 0; rd_stb = 0; byte_en = 2'b11; par_en = 1'b1; ext_master = 0;
        wr_data = '0; rd_data = 16'h0000; rd_par = 2'b00;   // bad parity on both lanes
        repeat (3) @(negedge clk);
        // R9: reset forces row phase and a quiet error flag
        check("R9 phase row in reset", {21'd0, dram_addr}, {21'd0, want_row(24'hAAAAAA)});
        check("R9 bus_err low in reset", {31'd0, bus_err}, 32'd0);
        col_sel = 1'b0; rd_par = 2'b11;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Address table: R1, R2, R3
        foreach (ADDR_TBL[k]) begin
            cpu_addr = ADDR_TBL[k];
            col_sel  = 1'b0;
            @(negedge clk);
            check("R1 row window", {21'd0, dram_addr}, {21'd0, want_row(ADDR_TBL[k])});
            col_sel = 1'b1;
            #1;
            check("R3 no change before edge", {21'd0, dram_addr}, {21'd0, want_row(ADDR_TBL[k])});
            @(negedge clk);
            check("R2 column window", {21'd0, dram_addr}, {21'd0, want_col(ADDR_TBL[k])});
            col_sel = 1'b0;
            #1;
            check("R3 column held before edge", {21'd0, dram_addr}, {21'd0, want_col(ADDR_TBL[k])});
        end

        // Parity table: R4..R8
        foreach (PAR_TBL[k]) begin
            logic [15:0] d;
            logic [1:0]  be, cor, good, exp_par;
            logic        pe, xm, act, exp_err;
            string       wtag, rtag;
            {d, be, pe, xm, cor} = PAR_TBL[k];
            act  = pe && !xm;
            good = {odd_bit(d[7:0]), odd_bit(d[15:8])};
            exp_par = act ? (good & be) : 2'b00;
            exp_err = act && |(cor & be);
            wtag = !pe ? "R7 write" : xm ? "R8 write" : "R4 write parity";
            rtag = !pe ? "R7 read"  : xm ? "R8 read"  : (be != 2'b11) ? "R6 read lane" : "R5 read";

            @(negedge clk);
            wr_data = d; byte_en = be; par_en = pe; ext_master = xm;
            wr_stb = 1'b1; rd_stb = 1'b0;
            #1;
            check(wtag, {30'd0, par_out}, {30'd0, exp_par});
            @(negedge clk);
            wr_stb = 1'b0; rd_stb = 1'b1;
            rd_data = d; rd_par = good ^ cor;
            @(negedge clk);
            rd_stb = 1'b0;
            check(rtag, {31'd0, bus_err}, {31'd0, exp_err});
            @(negedge clk);
            check("R5 single-cycle pulse", {31'd0, bus_err}, 32'd0);
        end

        // R10: bad parity without a read strobe
        @(negedge clk);
        par_en = 1'b1; ext_master = 1'b0; byte_en = 2'b11;
        rd_data = 16'h0F0F; rd_par = 2'b00; rd_stb = 1'b0;
        @(negedge clk);
        check("R10 no strobe no error", {31'd0, bus_err}, 32'd0);

        // R5 directed: upper lane alone corrupted, fixed literal values
        rd_data = 16'h0300; rd_par = 2'b10;  // 0x03 has two ones, bit 0 = 0 -> even
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R5 upper lane mismatch", {31'd0, bus_err}, 32'd1);

        // R4 directed literals: 0x00 -> 1, 0x01 -> 0
        wr_data = 16'h0001; wr_stb = 1'b1; byte_en = 2'b11;
        #1;
        check("R4 literal lanes", {30'd0, par_out}, {30'd0, 2'b01});
        wr_stb = 1'b0;
        #1;
        check("R4 idle outside write", {30'd0, par_out}, 32'd0);

        // R9: reset mid-run clears phase
        @(negedge clk);
        cpu_addr = 24'h123456; col_sel = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset returns row", {21'd0, dram_addr}, {21'd0, want_row(24'h123456)});
        rst = 1'b0; col_sel = 1'b0;
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule